// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that acts as a small byte-wide serial EEPROM. A bus master addresses it with a control byte. The control byte carries a fixed four-bit device code, three block-select bits and the R/W bit. The block oversamples SCL and SDA on the system clock and pulls SDA low through an open-drain enable. Behind the bus logic sit a 2048-byte store and an 11-bit address pointer. The pointer stays valid across transactions.

A write command carries a word address and then any number of data bytes. Each data byte is stored at the pointer, and the pointer then steps forward. The STOP that closes a write starts a timed write cycle of a parameterised number of clocks. While that cycle runs, the block ignores every control byte, so a master can poll with a write control byte until it gets an acknowledge. A write-protect input blocks all programming. The master can read in three ways: from the current pointer, from an address it set with a dummy write followed by a repeated START, or as a sequential run that the master continues by acknowledging each byte.

There is no data stream at the block's edge. All pins are plain control lines, and SDA carries no back-pressure other than the ACK/NACK bit of the protocol itself.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, and after any STOP (SDA rising while SCL is high), the block releases SDA (`sda_oe` = 0) and waits for a START (SDA falling while SCL is high).
- R2: A control byte whose upper four bits are 1010 is acknowledged when no write cycle is running. Any other code gets no acknowledge, and the block leaves SDA released until the next START.
- R3: In a write command, the second byte is the word address. It is joined with control-byte bits 3:1 (the upper bits) to form an 11-bit pointer. Each following data byte is acknowledged and stored at the pointer, which then increments and wraps from 2047 to 0.
- R4: A STOP that ends a write which stored at least one byte starts a busy period of exactly WR_CYCLES clocks. During this period no control byte (read or write) is acknowledged and the memory is not modified.
- R5: Once the busy period has ended, a START followed by a write control byte (1010xxx0) is acknowledged.
- R6: While `wp_i` is high, data bytes are still acknowledged and still advance the pointer, but the memory is left unchanged and the closing STOP starts no busy period.
- R7: A read control byte (R/W = 1) is acknowledged and returns the byte at the pointer. The pointer holds the address after the last byte written or read, so a read issued after an access to address n returns address n+1. The block-select bits of a read control byte are ignored.
- R8: A word-address write followed by a repeated START and a read control byte returns the byte at that address.
- R9: When the master acknowledges a read byte, the block sends the byte at the next address, MSB first, wrapping from 2047 to 0.
- R10: After the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START.
- R11: The block starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired level) |
| sda_oe | output | 1 | Pull SDA low when 1; release when 0 |
| wp_i | input | 1 | Write protect; 1 blocks all programming |

## Verification
Most wrong internal states surface at the ports within one byte time. A bad pointer shows up as a wrong data byte on the next read. A lost busy count shows up as an acknowledge on the very first poll after a STOP, or as polls that never get an acknowledge. A corrupted bit counter shifts the acknowledge slot, so the master sees a NACK or a bit-shifted byte in the same transfer. Write-protect leaks only become visible on a later read of the protected address, so the bench reads back right after each protected write.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } ee_state_t;
endpackage

// File: rtl/i2c_ee_line_sync.sv
// Brings SCL/SDA into the clock domain and flags edges and bus conditions.
module i2c_ee_line_sync #(
  parameter int STAGES = 2  // at least 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_s;
      sda_p    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_ee_wr_timer.sv
// Counts out the internal write cycle; busy for exactly CYCLES clocks after kick.
module i2c_ee_wr_timer #(
  parameter int unsigned CYCLES = 1000  // at least 1
)(
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)            remain <= '0;
    else if (kick)         remain <= CW'(CYCLES);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/i2c_ee_store.sv
// Byte array with one write port and one registered read port.
module i2c_ee_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int          ADDR_W      = 11,       // 9..11: control byte holds up to 3 block bits
  parameter logic [3:0]  DEV_CODE    = 4'b1010,
  parameter int unsigned WR_CYCLES   = 250000,   // 5 ms at 50 MHz
  parameter int          SYNC_STAGES = 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic wp_i
);
  localparam int BLK_W = ADDR_W - BYTE_W;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, wc_kick;
  ee_state_t state;
  logic [3:0] bit_cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr, rd_data, mem_wdata;
  logic [ADDR_W-1:0] ptr, mem_waddr;
  logic [BLK_W-1:0] blk;
  logic rw, m_ack, wr_pending, mem_we, oe_q;
  logic byte_done, dev_hit, rx_phase;

  i2c_ee_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ee_wr_timer #(.CYCLES(WR_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .kick(wc_kick), .busy(busy)
  );

  i2c_ee_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) i_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rd_data)
  );

  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign dev_hit   = (rx_sr[7:4] == DEV_CODE) && !busy;
  assign rx_phase  = (state == ST_CTRL) || (state == ST_ADDR) || (state == ST_WDATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      ptr        <= '0;
      blk        <= '0;
      rw         <= 1'b0;
      m_ack      <= 1'b0;
      wr_pending <= 1'b0;
      mem_we     <= 1'b0;
      mem_waddr  <= '0;
      mem_wdata  <= '0;
      oe_q       <= 1'b0;
      wc_kick    <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      wc_kick <= 1'b0;
      if (start_det) begin
        state   <= ST_CTRL;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else if (stop_det) begin
        state      <= ST_IDLE;
        oe_q       <= 1'b0;
        wc_kick    <= wr_pending;
        wr_pending <= 1'b0;
      end else begin
        if (rx_phase && scl_rise && bit_cnt != 4'd8) begin
          rx_sr   <= {rx_sr[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end
        case (state)
          ST_CTRL: if (byte_done) begin
            if (dev_hit) begin
              blk   <= rx_sr[BLK_W:1];
              rw    <= rx_sr[0];
              oe_q  <= 1'b1;
              state <= ST_CTRL_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_CTRL_ACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (rw) begin
              tx_sr <= rd_data;
              oe_q  <= ~rd_data[BYTE_W-1];
              ptr   <= ptr + 1'b1;
              state <= ST_RDATA;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_ADDR;
            end
          end
          ST_ADDR: if (byte_done) begin
            ptr   <= {blk, rx_sr};
            oe_q  <= 1'b1;
            state <= ST_ADDR_ACK;
          end
          ST_WDATA: if (byte_done) begin
            if (!wp_i) begin
              mem_we     <= 1'b1;
              mem_waddr  <= ptr;
              mem_wdata  <= rx_sr;
              wr_pending <= 1'b1;
            end
            ptr   <= ptr + 1'b1;
            oe_q  <= 1'b1;
            state <= ST_WDATA_ACK;
          end
          ST_ADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
            oe_q    <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_WDATA;
          end
          ST_RDATA: if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              oe_q  <= 1'b0;
              state <= ST_RACK;
            end else begin
              tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
              oe_q    <= ~tx_sr[BYTE_W-2];
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise) m_ack <= ~sda_s;
            if (scl_fall) begin
              if (m_ack) begin
                tx_sr   <= rd_data;
                oe_q    <= ~rd_data[BYTE_W-1];
                ptr     <= ptr + 1'b1;
                bit_cnt <= '0;
                state   <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker
  import i2c_ee_pkg::*;
#(
  parameter int          ADDR_W    = 11,
  parameter int unsigned WR_CYCLES = 1
)(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              wp_i,
  input logic              busy,
  input logic              stop_det,
  input logic              mem_we,
  input logic [ADDR_W-1:0] ptr,
  input logic [ADDR_W-1:0] mem_waddr,
  input ee_state_t         state
);
  logic [31:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  assert_release_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_no_ack_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state != ST_CTRL_ACK));

  assert_no_store_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_we);

  assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == WR_CYCLES));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ptr == ADDR_W'(mem_waddr + 1'b1)));

  assert_protect_blocks_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(wp_i));
endmodule

bind i2c_eeprom_target i2c_ee_checker #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) i_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wp_i(wp_i),
  .busy(busy), .stop_det(stop_det), .mem_we(mem_we), .ptr(ptr),
  .mem_waddr(mem_waddr), .state(state)
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  localparam int          AW  = 11;
  localparam int          MSK = (1 << AW) - 1;
  localparam int unsigned WRC = 600;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_oe = 1'b0, wp = 1'b0;
  logic sda_oe, sda_bus, oe_d = 1'b0;
  int checks = 0, errors = 0, hi_viol = 0;
  logic [7:0] model [1 << AW];
  logic [7:0] wbuf [8];

  assign sda_bus = ~(m_oe | sda_oe);
  always #10 clk = ~clk;

  i2c_eeprom_target #(.ADDR_W(AW), .WR_CYCLES(WRC)) i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe), .wp_i(wp)
  );

  // R11 monitor: a new pull-down must never appear while SCL is high
  always @(negedge clk) begin
    if (sda_oe && !oe_d && m_scl) hi_viol++;
    oe_d = sda_oe;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    m_oe = 1'b0; q(); m_scl = 1'b1; q(); m_oe = 1'b1; q(); m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_oe = 1'b1; q(); m_scl = 1'b1; q(); m_oe = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_oe = ~b[i]; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    end
    m_oe = 1'b0; q(); m_scl = 1'b1; q(); ack = ~sda_bus; q(); m_scl = 1'b0; q();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      q(); m_scl = 1'b1; q(); b[i] = sda_bus; q(); m_scl = 1'b0;
    end
    q(); m_oe = mack; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    m_oe = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(input int addr, input logic rd);
    return {4'b1010, 3'(addr >> 8), rd};
  endfunction

  task automatic write_bytes(input int addr, input int n);
    logic ack;
    bus_start();
    send_byte(ctrl(addr, 1'b0), ack); check("R2", "write control ack", ack, 1);
    send_byte(addr[7:0], ack);        check("R3", "word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);
      check(wp ? "R6" : "R3", "data ack", ack, 1);
      if (!wp) model[(addr + k) & MSK] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic poll(output int nacks, output logic got);
    logic ack;
    nacks = 0; got = 1'b0;
    for (int t = 0; t < 12 && !got; t++) begin
      bus_start(); send_byte(8'hA0, ack); bus_stop();
      if (ack) got = 1'b1; else nacks++;
    end
  endtask

  task automatic rand_read(input string req, input int addr, input int n);
    logic ack; logic [7:0] d;
    bus_start();
    send_byte(ctrl(addr, 1'b0), ack); check(req, "dummy write control ack", ack, 1);
    send_byte(addr[7:0], ack);        check(req, "dummy word address ack", ack, 1);
    bus_start();
    send_byte(8'hA1, ack);            check("R7", "read control ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      check(k == 0 ? req : "R9", "read data", d, model[(addr + k) & MSK]);
    end
    check("R10", "SDA released after master NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic cur_read(input int exp_addr);
    logic ack; logic [7:0] d;
    bus_start();
    send_byte(8'hA1, ack); check("R7", "current read control ack", ack, 1);
    recv_byte(1'b0, d);    check("R7", "current read data", d, model[exp_addr & MSK]);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nacks, a, n;
    logic got, ack;
    void'($urandom(32'd5150));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "SDA released after reset", sda_oe, 0);

    // R2: foreign device code is ignored, block stays silent through the next byte
    bus_start();
    send_byte(8'h90, ack); check("R2", "foreign code not acked", ack, 0);
    send_byte(8'h00, ack); check("R2", "silent after foreign code", ack, 0);
    bus_stop();
    check("R1", "SDA released after STOP", sda_oe, 0);

    // R3: write across the top of memory, pointer wraps 2047 -> 0
    for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
    write_bytes(12'h7FE, 4);
    // R4: read control during busy is refused, then poll for completion
    bus_start(); send_byte(8'hA1, ack); bus_stop();
    check("R4", "read control refused while busy", ack, 0);
    poll(nacks, got);
    check("R4", "poll refused at least once", int'(nacks >= 1), 1);
    check("R5", "poll acked after write cycle", got, 1);

    rand_read("R8", 12'h7FE, 4);     // R9 wrap across 2047 -> 0
    rand_read("R8", 12'h7FE, 1);
    cur_read(12'h7FF);               // R7
    cur_read(12'h000);               // R7 with wrap

    // R6: protected write is acked, leaves memory, starts no busy period
    wp = 1'b1;
    wbuf[0] = ~model[12'h7FF]; wbuf[1] = ~model[12'h000];
    write_bytes(12'h7FF, 2);
    poll(nacks, got);
    check("R6", "no busy after protected write", nacks, 0);
    wp = 1'b0;
    rand_read("R6", 12'h7FF, 2);

    // Random traffic
    for (int it = 0; it < 6; it++) begin
      a = int'($urandom) & MSK;
      n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      write_bytes(a, n);
      poll(nacks, got);
      check("R4", "random write busy refusal", int'(nacks >= 1), 1);
      check("R5", "random write completes", got, 1);
      rand_read("R8", a, n);
      cur_read(a + n);
    end

    check("R11", "pull-downs begun while SCL high", hi_viol, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule